// File: doc/BRIEF.md
# Conversion Result Buffer with Direct Bypass

This block sits between a data converter's conversion core and its output register. Each result is an 18-bit word: 16 data bits, a copy of the sign bit and an overflow flag. The buffer treats the word as opaque. A mode input selects between two paths. In direct mode every new result goes straight to the output register. In buffered mode results are queued in a 16-word first-in first-out store, and the oldest word is always presented at the output.

In buffered mode every conversion-complete strobe writes a word, whatever the level of the read line. The read line is asynchronous. It is synchronized to the system clock, and each rising edge moves the output to the next stored word. The falling edge that follows the read of the last word marks the store empty, and that word stays on the output. A two-bit status code reports the fill level. Driving direct mode while the read line is low empties the store. An active-low output enable gates the presented word. The enable is modelled as a drive flag together with a zeroed data bus.

Top module: `conv_sample_buffer`

## Requirements
- R1: After reset the status code is 01 (empty) and the presented word is all zeros.
- R2: In direct mode (`fifo_sel` = 0), a strobe on `wr_stb` loads `wr_word` into the output register, and the stored queue is left untouched.
- R3: In buffered mode (`fifo_sel` = 1), every `wr_stb` pulse stores `wr_word` whether `rd_line` is high or low.
- R4: A word written into an empty queue is presented at the output with no read edge.
- R5: Each synchronized rising edge of `rd_line` in buffered mode moves the output to the next stored word. From a full queue, 15 rising edges present the 16th word, and the queue never holds more than 16 words.
- R6: A strobe that arrives while the queue holds 16 words is discarded.
- R7: The status code `{stat[1],stat[0]}` is 01 when the queue is empty, 00 for 1 to 7 words, 10 for 8 to 15 words and 11 for 16 words. It is registered one cycle behind the fill count.
- R8: Once the last word has been read, the next falling edge of `rd_line` sets the status to empty, and the last word stays on the output. A read edge while the queue is empty changes nothing.
- R9: While `fifo_sel` is 0 and `rd_line` is low, the queue is emptied (status 01). In direct mode, strobes do not enter the queue.
- R10: While `oe_n` is 1, `out_drive` is 0 and `out_data` is all zeros. While `oe_n` is 0, `out_drive` is 1 and `out_data` shows the presented word.
- R11: A write and a read advance that land in the same cycle both take effect: the count is unchanged and the output moves to the next word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_sel | input | 1 | Asynchronous mode select: 1 = buffered, 0 = direct |
| rd_line | input | 1 | Asynchronous read line; rising edges advance the output |
| wr_stb | input | 1 | One-cycle conversion-complete strobe, synchronous to `clk` |
| wr_word | input | 18 | Result word that comes with `wr_stb` |
| oe_n | input | 1 | Active-low output enable |
| out_data | output | 18 | Presented word, zero while disabled |
| out_drive | output | 1 | High while the output bus is driven |
| stat | output | 2 | Fill-level status code |

## Verification
A conversion strobe and a synchronized read edge can arrive in the same clock cycle, so the queue has to push and pop at once. The bench provokes this by raising `rd_line` two cycles before it pulses `wr_stb`, which lines the strobe up with the detected edge. It then judges the result by the presented word, which must advance, and by a later drain sequence, which must find exactly the expected words. A flush request and a pending queue also meet at the mode switch. That case is judged by writing after the flush and checking that the new word appears at once.

// File: rtl/conv_buf_pkg.sv
// Shared status encoding for the conversion result buffer.
// Assumes the fill count never exceeds the depth it is compared against.
package conv_buf_pkg;

    typedef enum logic [1:0] {
        ST_PART  = 2'b00,
        ST_EMPTY = 2'b01,
        ST_HALF  = 2'b10,
        ST_FULL  = 2'b11
    } fill_stat_t;

    // Map a fill count onto the two-bit status code.
    function automatic fill_stat_t stat_encode(input int unsigned cnt, input int unsigned depth);
        if (cnt == 0)
            return ST_EMPTY;
        else if (cnt >= depth)
            return ST_FULL;
        else if (cnt >= depth / 2)
            return ST_HALF;
        else
            return ST_PART;
    endfunction

endpackage

// File: rtl/cbuf_sync.sv
// Multi-flop synchronizer for one asynchronous level.
// Assumes STAGES >= 1; the output resets low.
module cbuf_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level
);
    logic [STAGES-1:0] sh_q;

    // Shift the raw input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sh_q <= '0;
        else
            sh_q <= STAGES'({sh_q, async_in});
    end

    assign level = sh_q[STAGES-1];
endmodule

// File: rtl/cbuf_status.sv
// Registered fill-level status code.
// Assumes cnt is the store's registered fill count.
module cbuf_status
    import conv_buf_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    output fill_stat_t       stat_q
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    // Register the encoded status one cycle after the count.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stat_q <= ST_EMPTY;
        else
            stat_q <= stat_encode(int'(cnt), DEPTH);
    end

    // R7
    stat_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0) |=> (stat_q == ST_EMPTY));

    // R7
    stat_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == FULL_CNT) |=> (stat_q == ST_FULL));
endmodule

// File: rtl/cbuf_store.sv
// Circular word store with a presented-head output.
// The head word is presented as soon as it exists. A rise that leaves one
// word arms a drain, and the next fall then empties the store. A write to
// a full store is dropped. Assumes DEPTH is a power of two.
module cbuf_store #(
    parameter  int DEPTH  = 16,
    parameter  int WORD_W = 18,
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              push_req,
    input  logic [WORD_W-1:0] push_word,
    input  logic              rd_rise,
    input  logic              rd_fall,
    output logic [CNT_W-1:0]  count_q,
    output logic              pres_load,
    output logic [WORD_W-1:0] pres_word
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr_q;
    logic [PTR_W-1:0]  rd_ptr_q;
    logic [PTR_W-1:0]  rd_ptr_n;
    logic [CNT_W-1:0]  count_n;
    logic              arm_q;
    logic              wr_ok;
    logic              pop;

    // Decide the push, the pop, the next count and the next head word.
    always_comb begin
        wr_ok     = push_req && (count_q != FULL_CNT);
        pop       = (rd_rise && (count_q > ONE_CNT)) ||
                    (rd_fall && arm_q && (count_q == ONE_CNT));
        count_n   = count_q + CNT_W'(wr_ok) - CNT_W'(pop);
        rd_ptr_n  = pop ? rd_ptr_q + PTR_W'(1) : rd_ptr_q;
        pres_load = (wr_ok || pop) && (count_n != '0) && !flush;
        pres_word = (wr_ok && (rd_ptr_n == wr_ptr_q)) ? push_word : mem[rd_ptr_n];
    end

    // Keep the pointers, the count and the drain arm.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
            arm_q    <= 1'b0;
        end else begin
            if (wr_ok)
                wr_ptr_q <= wr_ptr_q + PTR_W'(1);
            rd_ptr_q <= rd_ptr_n;
            count_q  <= count_n;
            if (rd_rise && (count_n == ONE_CNT))
                arm_q <= 1'b1;
            else if (wr_ok || pop)
                arm_q <= 1'b0;
        end
    end

    // Write accepted words into the array.
    always_ff @(posedge clk) begin
        if (wr_ok)
            mem[wr_ptr_q] <= push_word;
    end

    // R5
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= FULL_CNT);

    // R6
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && (count_q == FULL_CNT) && !rd_rise && !rd_fall && !flush)
        |=> (count_q == FULL_CNT));

    // R9
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count_q == '0));

    // R11
    rw_same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && rd_rise && (count_q > ONE_CNT) && (count_q != FULL_CNT) && !flush)
        |=> $stable(count_q));
endmodule

// File: rtl/conv_sample_buffer.sv
// Conversion result buffer with a direct bypass.
// Synchronizes the mode and read lines, detects read edges, and routes
// either the strobed result or the store's head into the output register.
// Assumes wr_stb is a single-cycle pulse in the clk domain.
module conv_sample_buffer
    import conv_buf_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int WORD_W      = 18,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_sel,
    input  logic              rd_line,
    input  logic              wr_stb,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              oe_n,
    output logic [WORD_W-1:0] out_data,
    output logic              out_drive,
    output logic [1:0]        stat
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic              mode_s;
    logic              rd_s;
    logic              rd_prev_q;
    logic              flush;
    logic              push_req;
    logic              rd_rise;
    logic              rd_fall;
    logic [CNT_W-1:0]  fifo_cnt;
    logic              pres_load;
    logic [WORD_W-1:0] pres_word;
    logic [WORD_W-1:0] word_q;
    fill_stat_t        stat_q;

    cbuf_sync #(.STAGES(SYNC_STAGES)) u_mode_sync (
        .clk(clk), .rst_n(rst_n), .async_in(fifo_sel), .level(mode_s)
    );

    cbuf_sync #(.STAGES(SYNC_STAGES)) u_rd_sync (
        .clk(clk), .rst_n(rst_n), .async_in(rd_line), .level(rd_s)
    );

    // Remember the last synchronized read level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_prev_q <= 1'b0;
        else
            rd_prev_q <= rd_s;
    end

    // Gate the store's commands by the mode.
    always_comb begin
        flush    = !mode_s && !rd_s;
        push_req = mode_s && wr_stb;
        rd_rise  = mode_s && rd_s && !rd_prev_q;
        rd_fall  = mode_s && !rd_s && rd_prev_q;
    end

    cbuf_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_store (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push_req(push_req), .push_word(wr_word),
        .rd_rise(rd_rise), .rd_fall(rd_fall),
        .count_q(fifo_cnt), .pres_load(pres_load), .pres_word(pres_word)
    );

    cbuf_status #(.DEPTH(DEPTH)) u_status (
        .clk(clk), .rst_n(rst_n), .cnt(fifo_cnt), .stat_q(stat_q)
    );

    // Load the output register from the bypass or from the store head.
    always_ff @(posedge clk) begin
        if (!rst_n)
            word_q <= '0;
        else if (!mode_s && wr_stb)
            word_q <= wr_word;
        else if (pres_load)
            word_q <= pres_word;
    end

    assign stat      = stat_q;
    assign out_drive = !oe_n;
    assign out_data  = oe_n ? '0 : word_q;

    // R2
    bypass_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_s && wr_stb) |=> (word_q == $past(wr_word)));

    // R4
    first_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_s && wr_stb && (fifo_cnt == '0)) |=> (word_q == $past(wr_word)));

    // R8
    empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_s && !wr_stb && (fifo_cnt == '0)) |=> $stable(word_q));
endmodule

// File: tb/conv_sample_buffer_tb.sv
// Self-checking bench for conv_sample_buffer: fill, drain, overflow, bypass,
// flush, output enable and a coinciding write and read.
module conv_sample_buffer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fifo_sel = 1'b1;
    logic        rd_line = 1'b1;
    logic        wr_stb = 1'b0;
    logic [17:0] wr_word = '0;
    logic        oe_n = 1'b0;
    logic [17:0] out_data;
    logic        out_drive;
    logic [1:0]  stat;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    conv_sample_buffer u_dut (
        .clk(clk), .rst_n(rst_n), .fifo_sel(fifo_sel), .rd_line(rd_line),
        .wr_stb(wr_stb), .wr_word(wr_word), .oe_n(oe_n),
        .out_data(out_data), .out_drive(out_drive), .stat(stat)
    );

    function automatic logic [17:0] wv(input int i);
        return 18'((i * 7919 + 13) ^ 'h2A5A5);
    endfunction

    function automatic logic [1:0] exp_stat(input int n);
        if (n == 0)  return 2'b01;
        if (n >= 16) return 2'b11;
        if (n >= 8)  return 2'b10;
        return 2'b00;
    endfunction

    task automatic check(input string tag, input logic [17:0] got, input logic [17:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write(input int i);
        wr_word = wv(i);
        wr_stb  = 1'b1;
        tick(1);
        wr_stb  = 1'b0;
        tick(2);
    endtask

    task automatic set_rd(input logic v);
        rd_line = v;
        tick(5);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        tick(4);
        rst_n = 1'b1;
        tick(5);
        check("R1 status", {16'b0, stat}, 18'b01);
        check("R1 word", out_data, '0);

        // R4 first word shown at once, R3 with read high, R7 levels
        write(0);
        check("R4 first word", out_data, wv(0));
        check("R7 one word", {16'b0, stat}, {16'b0, exp_stat(1)});
        for (int k = 1; k < 16; k++) begin
            write(k);
            check("R7 fill", {16'b0, stat}, {16'b0, exp_stat(k + 1)});
            check("R3 head held", out_data, wv(0));
        end
        // R6 dropped write at full
        write(99);
        check("R6 full status", {16'b0, stat}, 18'b11);
        check("R6 head", out_data, wv(0));

        // R5 drain by rising edges
        set_rd(1'b0);
        for (int k = 1; k < 16; k++) begin
            set_rd(1'b1);
            check("R5 advance", out_data, wv(k));
            check("R7 drain", {16'b0, stat}, {16'b0, exp_stat(16 - k)});
            set_rd(1'b0);
        end
        // R8 empty after the falling edge, last word held
        check("R8 empty", {16'b0, stat}, 18'b01);
        check("R8 last word", out_data, wv(15));
        check("R6 dropped word absent", out_data, wv(15));
        set_rd(1'b1);
        check("R8 read when empty", out_data, wv(15));
        check("R8 status stays", {16'b0, stat}, 18'b01);
        set_rd(1'b0);

        // R3 write with read line low
        write(40);
        check("R3 read low write", out_data, wv(40));
        write(41);
        // R11 coinciding write and read edge
        rd_line = 1'b1;
        tick(2);
        wr_word = wv(42);
        wr_stb  = 1'b1;
        tick(1);
        wr_stb  = 1'b0;
        tick(3);
        check("R11 advanced", out_data, wv(41));
        check("R11 count", {16'b0, stat}, 18'b00);
        set_rd(1'b0);
        set_rd(1'b1);
        check("R11 written word", out_data, wv(42));
        set_rd(1'b0);
        check("R11 drained", {16'b0, stat}, 18'b01);

        // R2 bypass load, R9 bypass writes kept out of the queue
        set_rd(1'b1);
        write(20);
        write(21);
        write(22);
        fifo_sel = 1'b0;
        tick(5);
        write(23);
        check("R2 bypass word", out_data, wv(23));
        check("R2 status kept", {16'b0, stat}, 18'b00);
        fifo_sel = 1'b1;
        tick(5);
        set_rd(1'b0);
        set_rd(1'b1);
        check("R2 queue intact", out_data, wv(21));
        set_rd(1'b0);
        set_rd(1'b1);
        check("R9 queue order", out_data, wv(22));
        set_rd(1'b0);
        check("R9 bypass write ignored", {16'b0, stat}, 18'b01);

        // R9 flush by direct mode with read low
        set_rd(1'b1);
        write(24);
        write(25);
        check("R9 pre-flush", {16'b0, stat}, 18'b00);
        fifo_sel = 1'b0;
        rd_line  = 1'b0;
        tick(5);
        check("R9 flushed", {16'b0, stat}, 18'b01);
        fifo_sel = 1'b1;
        rd_line  = 1'b1;
        tick(5);
        write(30);
        check("R9 fresh head", out_data, wv(30));
        check("R9 one word", {16'b0, stat}, 18'b00);

        // R10 output enable
        oe_n = 1'b1;
        #1;
        check("R10 data off", out_data, '0);
        check("R10 drive off", {17'b0, out_drive}, 18'b0);
        oe_n = 1'b0;
        #1;
        check("R10 data on", out_data, wv(30));
        check("R10 drive on", {17'b0, out_drive}, 18'b1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule